// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins (94 by default). Software reaches it through a plain register bus: a write strobe with address and data, and a read data path that is combinational on the address. Some state is packed 32 pins per word: ownership, interrupt status and interrupt enable. Each pin also owns a pair of configuration words. The first holds the mode, direction, output level, trigger type and the live input level. The second holds an input-sense disable and a two-bit weak-pull choice.

Pad inputs pass through a two-flop synchroniser. A per-pin detector then turns the synchronised level into an interrupt event, according to the pin's trigger type. The type is a two-bit code: one bit picks edge or level, and the other bit flips the polarity. Events set sticky status bits, and software clears these by writing ones. The controller drives one shared interrupt output while any pin has both its status and its enable bit set. The pad output enable, the output value and the pull selection are driven straight from the configuration state.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every pin is an input (direction bit 1) in GPIO mode (mode bit 1) with sensing disabled. All status and enable bits are 0. Every implemented ownership bit is 1, pad_oe is all 0 and irq_out is 0.
- R2: The address map is as follows. Ownership words are at 0x00+4w, status words at 0x80+4w and enable words at 0x90+4w; pin p is in word p/32 at bit p%32, and bits for pins that do not exist read 0. A read/write global word is at 0x7C. Config word 1 of pin p is at 0x100+8p and config word 2 at 0x104+8p. Unmapped addresses read 0.
- R3: Config word 1 has these fields: bit 31 output level, bit 30 input level (read-only), bit 4 trigger select, bit 3 trigger invert, bit 2 direction (1 input), bit 0 mode (1 GPIO). All other bits read 0.
- R4: Config word 2 has bit 2 as sense disable and bits 1:0 as the pull choice, and the pull choice appears on pull_sel[2p+1:2p]. All other bits read 0.
- R5: pad_oe[p] is 1 exactly when the mode bit is 1 and the direction bit is 0. pad_out[p] then equals the output-level bit, and is 0 otherwise.
- R6: The input level in bit 30 follows the pad two clock edges after the pad changes. It reads 0 while sensing is disabled or the mode bit is 0.
- R7: The trigger code {select, invert} means 00 rising edge, 01 falling edge, 10 level low, 11 level high. A qualifying pad change sets the status bit on the third clock edge after the change.
- R8: A level trigger sets its status bit on every cycle its condition holds, so clearing the bit while the condition still holds does not leave it clear.
- R9: Writing 1 to a status bit clears it; writing 0 leaves it unchanged.
- R10: An event that arrives in the same cycle as a clearing write to that bit leaves the bit set.
- R11: A pin with sensing disabled or mode bit 0 sets no status bit, whatever its pad does.
- R12: Enable words read back what was written, masked to existing pins. irq_out is 1 exactly when some pin has both status and enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| pull_sel | output | 2*NUM_PINS | Weak-pull choice, two bits per pin |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A clearing write to a status word and a fresh trigger event on the same bit can land on the same clock edge. That collision is the race the design must settle. The bench provokes it by counting edges from a pad change, so that a write of one to that status bit is committed on exactly the edge where the edge detector fires. The bench then judges it by reading the bit back as still set. A later clearing write with no event pending must clear the bit. In the same way, a level trigger held active while software clears it must show the bit set again on the next read.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Trigger code {select, invert}
    typedef enum logic [1:0] {
        TRIG_RISE   = 2'b00,
        TRIG_FALL   = 2'b01,
        TRIG_LVL_LO = 2'b10,
        TRIG_LVL_HI = 2'b11
    } trig_e;

    // Address bits [7:4] of the low page select a bitmapped bank
    localparam logic [3:0] BANK_OWN  = 4'h0;
    localparam logic [3:0] BANK_STAT = 4'h8;
    localparam logic [3:0] BANK_EN   = 4'h9;
    localparam logic [7:0] GCFG_OFS  = 8'h7C;

    // Pin config area starts at 0x100, eight bytes per pin
    localparam int unsigned CFG_BASE_DW = 32;

    // Config word 1 bit positions
    localparam int unsigned C1_OUT  = 31;
    localparam int unsigned C1_IN   = 30;
    localparam int unsigned C1_TSEL = 4;
    localparam int unsigned C1_TINV = 3;
    localparam int unsigned C1_DIR  = 2;
    localparam int unsigned C1_USE  = 0;

    // Config word 2 bit position
    localparam int unsigned C2_SDIS = 2;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] s1_q, s1_d, s2_q, s2_d;

    always_comb begin
        s1_d = din;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign dout = s2_q;

    // R6: output is the input delayed by exactly two edges
    p_two_flop_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n)) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lvl_i,
    input  logic  active_i,
    input  trig_e trig_i,
    output logic  event_o
);

    logic prev_q, prev_d;
    logic hit;

    always_comb begin
        prev_d = lvl_i;
        unique case (trig_i)
            TRIG_RISE:   hit = lvl_i & ~prev_q;
            TRIG_FALL:   hit = ~lvl_i & prev_q;
            TRIG_LVL_LO: hit = ~lvl_i;
            default:     hit = lvl_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign event_o = hit & active_i;

    // R11: an idle pin never produces an event
    p_idle_no_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |-> !event_o);

    // R7: a rising-edge event lasts a single cycle
    p_edge_one_shot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && trig_i == TRIG_RISE) |=> !(event_o && trig_i == TRIG_RISE));

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 94,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [2*NUM_PINS-1:0] pull_sel,
    output logic                  irq_out
);

    localparam int unsigned NW     = (NUM_PINS + 31) / 32;
    localparam int unsigned BW     = NW * 32;
    localparam int unsigned PIDX_W = ADDR_W - 3;
    localparam logic [BW-1:0] PIN_MASK = (BW'(1) << NUM_PINS) - BW'(1);

    typedef struct packed {
        logic [BW-1:0]         own;
        logic [BW-1:0]         stat;
        logic [BW-1:0]         en;
        logic [31:0]           gcfg;
        logic [NUM_PINS-1:0]   out_lvl;
        logic [NUM_PINS-1:0]   tsel;
        logic [NUM_PINS-1:0]   tinv;
        logic [NUM_PINS-1:0]   dir;
        logic [NUM_PINS-1:0]   use_gpio;
        logic [NUM_PINS-1:0]   sdis;
        logic [2*NUM_PINS-1:0] pull;
    } regs_t;

    regs_t r_q, r_d;

    // ---------------- address decode ----------------
    logic              low_page, aligned, word_ok;
    logic              hit_own, hit_stat, hit_en, hit_gcfg, hit_pin, hit_cfg2;
    logic [PIDX_W-1:0] pidx;
    int unsigned       wbase, pin_i;

    always_comb begin
        low_page = (bus_addr[ADDR_W-1:8] == '0);
        aligned  = (bus_addr[1:0] == 2'b00);
        word_ok  = (int'(bus_addr[3:2]) < NW);
        wbase    = int'(bus_addr[3:2]) * 32;
        pidx     = bus_addr[ADDR_W-1:3] - PIDX_W'(CFG_BASE_DW);
        pin_i    = int'(pidx);
        hit_own  = low_page && aligned && word_ok && bus_addr[7:4] == BANK_OWN;
        hit_stat = low_page && aligned && word_ok && bus_addr[7:4] == BANK_STAT;
        hit_en   = low_page && aligned && word_ok && bus_addr[7:4] == BANK_EN;
        hit_gcfg = low_page && bus_addr[7:0] == GCFG_OFS;
        hit_pin  = !low_page && aligned && pin_i < NUM_PINS;
        hit_cfg2 = bus_addr[2];
    end

    // ---------------- input path ----------------
    logic [NUM_PINS-1:0] pad_sync, active, in_lvl, evt_pin;
    logic [BW-1:0]       evt_vec;

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (pad_sync)
    );

    assign active = ~r_q.sdis & r_q.use_gpio;
    assign in_lvl = pad_sync & active;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpio_trig_detect u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl_i   (pad_sync[p]),
            .active_i(active[p]),
            .trig_i  (trig_e'({r_q.tsel[p], r_q.tinv[p]})),
            .event_o (evt_pin[p])
        );
    end

    always_comb begin
        evt_vec                 = '0;
        evt_vec[NUM_PINS-1:0]   = evt_pin;
    end

    // ---------------- next state ----------------
    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            if (hit_own)  r_d.own[wbase +: 32]  = bus_wdata & PIN_MASK[wbase +: 32];
            if (hit_en)   r_d.en[wbase +: 32]   = bus_wdata & PIN_MASK[wbase +: 32];
            if (hit_stat) r_d.stat[wbase +: 32] = r_q.stat[wbase +: 32] & ~bus_wdata;
            if (hit_gcfg) r_d.gcfg = bus_wdata;
            if (hit_pin && !hit_cfg2) begin
                r_d.out_lvl[pin_i]  = bus_wdata[C1_OUT];
                r_d.tsel[pin_i]     = bus_wdata[C1_TSEL];
                r_d.tinv[pin_i]     = bus_wdata[C1_TINV];
                r_d.dir[pin_i]      = bus_wdata[C1_DIR];
                r_d.use_gpio[pin_i] = bus_wdata[C1_USE];
            end
            if (hit_pin && hit_cfg2) begin
                r_d.sdis[pin_i]         = bus_wdata[C2_SDIS];
                r_d.pull[2*pin_i +: 2]  = bus_wdata[1:0];
            end
        end
        // new events win over a same-cycle clear
        r_d.stat = r_d.stat | evt_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.own      <= PIN_MASK;
            r_q.dir      <= '1;
            r_q.use_gpio <= '1;
            r_q.sdis     <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    // ---------------- read path ----------------
    always_comb begin
        bus_rdata = '0;
        if (hit_own)  bus_rdata = r_q.own[wbase +: 32];
        if (hit_stat) bus_rdata = r_q.stat[wbase +: 32];
        if (hit_en)   bus_rdata = r_q.en[wbase +: 32];
        if (hit_gcfg) bus_rdata = r_q.gcfg;
        if (hit_pin && !hit_cfg2)
            bus_rdata = {r_q.out_lvl[pin_i], in_lvl[pin_i], 25'b0,
                         r_q.tsel[pin_i], r_q.tinv[pin_i], r_q.dir[pin_i],
                         1'b0, r_q.use_gpio[pin_i]};
        if (hit_pin && hit_cfg2)
            bus_rdata = {29'b0, r_q.sdis[pin_i], r_q.pull[2*pin_i +: 2]};
    end

    // ---------------- pad and interrupt outputs ----------------
    assign pad_oe   = r_q.use_gpio & ~r_q.dir;
    assign pad_out  = r_q.out_lvl & pad_oe;
    assign pull_sel = r_q.pull;
    assign irq_out  = |(r_q.stat & r_q.en);

    // R9: bits written with one and not hit by an event are clear afterwards
    p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(12'h080))
        |=> ((r_q.stat[31:0] & $past(bus_wdata & ~evt_vec[31:0])) == 32'h0));

    // R10: an event is always recorded on the next edge
    p_event_recorded_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_vec) |=> (($past(evt_vec) & ~r_q.stat) == '0));

    // R12: no interrupt without an enable
    p_irq_needs_enable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en == '0) |-> !irq_out);

    // R12: enable word 0 takes the written value
    p_enable_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(12'h090))
        |=> (r_q.en[31:0] == ($past(bus_wdata) & PIN_MASK[31:0])));

    // R5: output enable only when the pin drives
    p_oe_follows_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_pin && !hit_cfg2 && !bus_wdata[C1_DIR] && bus_wdata[C1_USE]
         && pin_i == 0) |=> pad_oe[0]);

endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;

    localparam int unsigned NP = 94;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic [2*NP-1:0] pull_sel;
    logic          irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pull_sel(pull_sel), .irq_out(irq_out)
    );

    always #2 clk = ~clk;

    function automatic logic [11:0] c1a(input int p);
        return 12'(12'h100 + p * 8);
    endfunction
    function automatic logic [11:0] c2a(input int p);
        return 12'(12'h104 + p * 8);
    endfunction
    function automatic logic [31:0] exp_cfg1(input logic [31:0] d, input logic inl);
        logic [31:0] r;
        r = d & 32'h8000_001D;
        r[30] = inl;
        return r;
    endfunction
    function automatic logic [31:0] word_mask(input int w);
        return (w == 2) ? 32'h3FFF_FFFF : 32'hFFFF_FFFF;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        peek(a, d);
    endtask

    task automatic set_pad(input int p, input logic v);
        @(negedge clk);
        pad_in[p] = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, v;
        int p;
        void'($urandom(32'd6021));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // ---- R1 reset state ----
        rd(12'h000, d); check("R1 own word0", d, 32'hFFFF_FFFF);
        rd(12'h008, d); check("R1 own word2", d, 32'h3FFF_FFFF);
        rd(c1a(0), d);  check("R1 cfg1 pin0", d, 32'h0000_0005);
        rd(c2a(93), d); check("R1 cfg2 pin93", d, 32'h0000_0004);
        rd(12'h084, d); check("R1 status word1", d, 32'h0);
        rd(12'h090, d); check("R1 enable word0", d, 32'h0);
        check("R1 pad_oe", {31'b0, |pad_oe}, 32'h0);
        check("R1 irq_out", {31'b0, irq_out}, 32'h0);

        // ---- R2 map ----
        wr(12'h07C, 32'hA5C3_0F96);
        rd(12'h07C, d); check("R2 global word", d, 32'hA5C3_0F96);
        rd(12'h0FC, d); check("R2 unmapped low", d, 32'h0);
        rd(c1a(94), d); check("R2 beyond last pin", d, 32'h0);
        wr(12'h004, 32'h0000_0000);
        rd(12'h004, d); check("R2 own word1 write", d, 32'h0);
        rd(12'h000, d); check("R2 own word0 untouched", d, 32'hFFFF_FFFF);

        // ---- R3 R4 R5 constrained random config (sensing kept off) ----
        for (int i = 0; i < 24; i++) begin
            p = int'($urandom % NP);
            d = $urandom;
            wr(c1a(p), d);
            rd(c1a(p), v); check("R3 cfg1 readback", v, exp_cfg1(d, 1'b0));
            check("R5 pad_oe", {31'b0, pad_oe[p]}, {31'b0, d[0] & ~d[2]});
            check("R5 pad_out", {31'b0, pad_out[p]}, {31'b0, d[0] & ~d[2] & d[31]});
            d = $urandom | 32'h4;
            wr(c2a(p), d);
            rd(c2a(p), v); check("R4 cfg2 readback", v, d & 32'h7);
            check("R4 pull_sel", {30'b0, pull_sel[2*p +: 2]}, {30'b0, d[1:0]});
        end
        for (int w = 0; w < 3; w++) begin
            d = $urandom;
            wr(12'(12'h090 + 4 * w), d);
            rd(12'(12'h090 + 4 * w), v); check("R12 enable readback", v, d & word_mask(w));
            check("R12 no irq without status", {31'b0, irq_out}, 32'h0);
        end
        wr(12'h090, 0); wr(12'h094, 0); wr(12'h098, 0);

        // ---- R5 directed ----
        wr(c1a(5), 32'h8000_0001);
        check("R5 drive high oe", {31'b0, pad_oe[5]}, 32'h1);
        check("R5 drive high value", {31'b0, pad_out[5]}, 32'h1);
        wr(c1a(5), 32'h8000_0000);
        check("R5 native mode oe", {31'b0, pad_oe[5]}, 32'h0);
        check("R5 native mode value", {31'b0, pad_out[5]}, 32'h0);

        // ---- R6 synchroniser latency ----
        wr(c1a(3), 32'h5);
        wr(c2a(3), 32'h0);
        @(negedge clk); pad_in[3] = 1'b1;
        @(negedge clk); peek(c1a(3), d); check("R6 level after one edge", d, 32'h5);
        @(negedge clk); peek(c1a(3), d); check("R6 level after two edges", d, 32'h4000_0005);
        wr(c2a(3), 32'h4);
        rd(c1a(3), d); check("R6 sensing off reads 0", d, 32'h5);
        wr(12'h080, 32'hFFFF_FFFF);

        // ---- R7 R8 trigger types on pin 40 (word1 bit8) ----
        wr(c1a(40), 32'h05); wr(c2a(40), 32'h0);
        wr(12'h084, 32'hFFFF_FFFF);
        rd(12'h084, d); check("R7 rise idle", d, 32'h0);
        set_pad(40, 1'b1);
        peek(12'h084, d); check("R7 rising edge sets", d, 32'h100);
        wr(12'h084, 32'h100);
        rd(12'h084, d); check("R7 edge does not retrigger", d, 32'h0);
        wr(c1a(40), 32'h0D); wr(12'h084, 32'hFFFF_FFFF);
        set_pad(40, 1'b0);
        peek(12'h084, d); check("R7 falling edge sets", d, 32'h100);
        wr(c1a(40), 32'h1D); wr(12'h084, 32'hFFFF_FFFF);
        rd(12'h084, d); check("R7 level high idle when low", d, 32'h0);
        set_pad(40, 1'b1);
        peek(12'h084, d); check("R7 level high sets", d, 32'h100);
        wr(12'h084, 32'h100);
        peek(12'h084, d); check("R8 level high re-sets after clear", d, 32'h100);
        wr(c1a(40), 32'h15); wr(12'h084, 32'hFFFF_FFFF);
        rd(12'h084, d); check("R7 level low idle when high", d, 32'h0);
        set_pad(40, 1'b0);
        peek(12'h084, d); check("R7 level low sets", d, 32'h100);

        // ---- R12 combined interrupt ----
        wr(12'h094, 32'h200);
        check("R12 other enable no irq", {31'b0, irq_out}, 32'h0);
        wr(12'h094, 32'h100);
        check("R12 enabled pending irq", {31'b0, irq_out}, 32'h1);
        wr(12'h094, 32'h0);
        check("R12 disabled no irq", {31'b0, irq_out}, 32'h0);
        wr(c1a(40), 32'h05); wr(12'h084, 32'hFFFF_FFFF);

        // ---- R11 inactive pins ----
        wr(c1a(93), 32'h05); wr(c2a(93), 32'h4);
        set_pad(93, 1'b1);
        rd(12'h088, d); check("R11 sense off no status", d, 32'h0);
        rd(c1a(93), d); check("R11 sense off level", d, 32'h5);
        wr(c1a(93), 32'h04); wr(c2a(93), 32'h0);
        set_pad(93, 1'b0); set_pad(93, 1'b1);
        rd(12'h088, d); check("R11 native mode no status", d, 32'h0);
        rd(c1a(93), d); check("R11 native mode level", d, 32'h4);

        // ---- R9 R10 pin 0 ----
        wr(c1a(0), 32'h05); wr(c2a(0), 32'h0);
        wr(12'h080, 32'hFFFF_FFFF);
        set_pad(0, 1'b1);
        peek(12'h080, d); check("R7 pin0 rising sets", d, 32'h1);
        wr(12'h080, 32'h0);
        peek(12'h080, d); check("R9 write zero keeps bit", d, 32'h1);
        set_pad(0, 1'b0);
        @(negedge clk); pad_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h080; bus_wdata = 32'h1;
        @(negedge clk); bus_wr = 1'b0;
        peek(12'h080, d); check("R10 event wins over clear", d, 32'h1);
        wr(12'h080, 32'h1);
        peek(12'h080, d); check("R9 write one clears", d, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule